// File: doc/BRIEF.md
# Debug Mode Entry and Return Controller

This block owns the two registers of the processor's debug exception path: the debug control/status word and the saved return address. A debug event presented for one cycle records why the core stopped: a new cause type, the delay-slot flag and the debug-mode flags. It saves the interrupted PC together with the instruction-set mode bit, and steers fetch to a fixed debug vector. A debug-return request leaves debug mode and steers fetch back to the saved address.

Which conditions raise a debug event, and how an external probe reaches the core, are decided elsewhere. The pipeline drives `entry_req` or `return_req` and consumes the one-cycle `pc_load` redirect. It also consumes `irq_drop`, which tells the interrupt logic to forget any interrupt it was about to take.

Top module: `debug_mode_ctrl`

## Requirements
- R1: After reset, `debug_reg` and `depc_reg` are zero, `in_debug` is 0, and `pc_load`, `irq_drop` and `nested_entry` are 0.
- R2: On entry, every bit of the cause-type group in `debug_reg` is cleared, and then the bits of `entry_type` that lie in that group are set. The group is mask 0x000C7C3F: bits 5:0 (single-step, breakpoint, data-break load, data-break store, instruction break, debug interrupt), bits 14:10 (debug exception code) and bits 19:18 (imprecise load and store data breaks). Bits of `entry_type` outside the group have no effect.
- R3: On entry, bit 31 of `debug_reg` (delay-slot flag) takes the value of `in_delay_slot`.
- R4: On entry, bit 30 (debug mode) and bit 20 (exception-inhibit flag) of `debug_reg` are set. Bits outside the type group and bits 31, 30 and 20 keep their value.
- R5: On entry, `depc_reg` becomes `{cur_pc[31:1], cur_isa}`.
- R6: One cycle after an entry request, `pc_load` is 1, `new_pc` is 0xBFC00480 and `new_isa` is 0.
- R7: On a return request without entry, bits 30 and 20 of `debug_reg` clear and all its other bits hold. `depc_reg` holds. One cycle later `pc_load` is 1, `new_pc` is `{depc_reg[31:1], 0}` and `new_isa` is `depc_reg[0]`.
- R8: `irq_drop` is 1 for exactly the cycle after each entry request.
- R9: An entry request while bit 30 is already 1 still performs R2 to R6, and `nested_entry` is 1 in the following cycle. It is 0 after an entry taken from outside debug mode.
- R10: When entry and return are requested in the same cycle, only the entry takes effect.
- R11: In a cycle with no request, `debug_reg` and `depc_reg` hold, and in the next cycle `pc_load`, `irq_drop` and `nested_entry` are 0. `in_debug` always equals bit 30 of `debug_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_req | input | 1 | Take a debug exception this cycle |
| entry_type | input | 32 | Cause-type bits to record (group mask applied) |
| cur_pc | input | 32 | PC of the interrupted instruction |
| cur_isa | input | 1 | Instruction-set mode bit at the interrupted instruction |
| in_delay_slot | input | 1 | Interrupted instruction sits in a branch delay slot |
| return_req | input | 1 | Debug-return instruction executes this cycle |
| debug_reg | output | 32 | Debug control/status register |
| depc_reg | output | 32 | Saved debug return address with mode bit in bit 0 |
| new_pc | output | 32 | Redirect target, valid with pc_load |
| new_isa | output | 1 | Instruction-set mode bit for the redirect |
| pc_load | output | 1 | One-cycle fetch redirect strobe |
| in_debug | output | 1 | Core is in debug mode |
| nested_entry | output | 1 | The last entry happened while already in debug mode |
| irq_drop | output | 1 | Clear any pending-interrupt indication |

## Verification
Every result of this block sits in a register, so every output reflects a request exactly one clock edge after it is sampled. This holds for the two registers, the redirect strobe and target, and the nested and interrupt-drop pulses. The bench drives each request at a falling edge and compares all outputs at the next falling edge against a model it updates at that same step. A result a cycle early or late therefore shows as a mismatch. Idle cycles between requests confirm that the pulses last one cycle and that both registers hold.

// File: rtl/debug_mode_ctrl.sv
module debug_mode_ctrl #(
  parameter int          XLEN      = 32,
  parameter logic [31:0] DBG_VECTOR = 32'hBFC0_0480
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            entry_req,
  input  logic [XLEN-1:0] entry_type,
  input  logic [XLEN-1:0] cur_pc,
  input  logic            cur_isa,
  input  logic            in_delay_slot,
  input  logic            return_req,
  output logic [XLEN-1:0] debug_reg,
  output logic [XLEN-1:0] depc_reg,
  output logic [XLEN-1:0] new_pc,
  output logic            new_isa,
  output logic            pc_load,
  output logic            in_debug,
  output logic            nested_entry,
  output logic            irq_drop
);
  localparam int BIT_SLOT = 31;
  localparam int BIT_MODE = 30;
  localparam int BIT_INHB = 20;
  localparam logic [XLEN-1:0] TYPE_MASK = XLEN'(32'h000C_7C3F);
  localparam logic [XLEN-1:0] ONE       = XLEN'(1);
  localparam logic [XLEN-1:0] FLAG_SET  = (ONE << BIT_MODE) | (ONE << BIT_INHB);
  localparam logic [XLEN-1:0] SLOT_BIT  = ONE << BIT_SLOT;

  logic [XLEN-1:0] dbg_q, depc_q, pc_q;
  logic            isa_q, load_q, nest_q, drop_q;

  logic [XLEN-1:0] dbg_entry;
  assign dbg_entry = ((dbg_q & ~(TYPE_MASK | SLOT_BIT)) | (entry_type & TYPE_MASK) | FLAG_SET)
                   | (in_delay_slot ? SLOT_BIT : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbg_q  <= '0;
      depc_q <= '0;
      pc_q   <= '0;
      isa_q  <= 1'b0;
      load_q <= 1'b0;
      nest_q <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      load_q <= 1'b0;
      nest_q <= 1'b0;
      drop_q <= 1'b0;
      if (entry_req) begin
        dbg_q  <= dbg_entry;
        depc_q <= {cur_pc[XLEN-1:1], cur_isa};
        pc_q   <= DBG_VECTOR[XLEN-1:0];
        isa_q  <= 1'b0;
        load_q <= 1'b1;
        drop_q <= 1'b1;
        nest_q <= dbg_q[BIT_MODE];
      end else if (return_req) begin
        dbg_q  <= dbg_q & ~FLAG_SET;
        pc_q   <= {depc_q[XLEN-1:1], 1'b0};
        isa_q  <= depc_q[0];
        load_q <= 1'b1;
      end
    end
  end

  assign debug_reg    = dbg_q;
  assign depc_reg     = depc_q;
  assign new_pc       = pc_q;
  assign new_isa      = isa_q;
  assign pc_load      = load_q;
  assign in_debug     = dbg_q[BIT_MODE];
  assign nested_entry = nest_q;
  assign irq_drop     = drop_q;
endmodule

// File: rtl/debug_mode_ctrl_chk.sv
module debug_mode_ctrl_chk #(
  parameter logic [31:0] VEC = 32'hBFC0_0480
) (
  input logic        clk,
  input logic        rst_n,
  input logic        entry_req,
  input logic        return_req,
  input logic [31:0] cur_pc,
  input logic        cur_isa,
  input logic [31:0] debug_reg,
  input logic [31:0] depc_reg,
  input logic [31:0] new_pc,
  input logic        new_isa,
  input logic        pc_load,
  input logic        nested_entry,
  input logic        irq_drop
);
  assert_entry_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    entry_req |=> debug_reg[30] && debug_reg[20]);
  assert_depc_save_R5: assert property (@(posedge clk) disable iff (!rst_n)
    entry_req |=> depc_reg == {$past(cur_pc[31:1]), $past(cur_isa)});
  assert_entry_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    entry_req |=> pc_load && new_pc == VEC && !new_isa);
  assert_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (return_req && !entry_req) |=> !debug_reg[30] && !debug_reg[20] && pc_load
      && new_pc == {$past(depc_reg[31:1]), 1'b0} && new_isa == $past(depc_reg[0]));
  assert_irq_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    entry_req |=> irq_drop);
  assert_nested_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_req && debug_reg[30]) |=> nested_entry);
  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!entry_req && !return_req) |=> !pc_load && !irq_drop && !nested_entry
      && $stable(debug_reg) && $stable(depc_reg));
endmodule

bind debug_mode_ctrl debug_mode_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .return_req(return_req),
  .cur_pc(cur_pc), .cur_isa(cur_isa), .debug_reg(debug_reg), .depc_reg(depc_reg),
  .new_pc(new_pc), .new_isa(new_isa), .pc_load(pc_load),
  .nested_entry(nested_entry), .irq_drop(irq_drop)
);

// File: tb/debug_mode_ctrl_tb_top.sv
module debug_mode_ctrl_tb_top;
  localparam logic [31:0] VEC  = 32'hBFC0_0480;
  localparam logic [31:0] MASK = 32'h000C_7C3F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic entry_req = 1'b0, return_req = 1'b0, cur_isa = 1'b0, in_delay_slot = 1'b0;
  logic [31:0] entry_type = '0, cur_pc = '0;
  logic [31:0] debug_reg, depc_reg, new_pc;
  logic new_isa, pc_load, in_debug, nested_entry, irq_drop;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_dbg = '0, m_depc = '0;

  always #10 clk = ~clk;

  debug_mode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .entry_type(entry_type),
    .cur_pc(cur_pc), .cur_isa(cur_isa), .in_delay_slot(in_delay_slot),
    .return_req(return_req), .debug_reg(debug_reg), .depc_reg(depc_reg),
    .new_pc(new_pc), .new_isa(new_isa), .pc_load(pc_load), .in_debug(in_debug),
    .nested_entry(nested_entry), .irq_drop(irq_drop)
  );

  function automatic logic [31:0] f_entry(logic [31:0] d, logic [31:0] t, logic s);
    logic [31:0] r;
    r = (d & ~MASK) | (t & MASK);
    r[30] = 1'b1;
    r[20] = 1'b1;
    r[31] = s;
    return r;
  endfunction

  function automatic logic [31:0] f_return(logic [31:0] d);
    logic [31:0] r;
    r = d;
    r[30] = 1'b0;
    r[20] = 1'b0;
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(logic e, logic r, logic [31:0] t, logic [31:0] pc, logic isa, logic s);
    logic [31:0] e_dbg, e_depc, e_pc;
    logic e_load, e_isa, e_nest, e_drop;
    entry_req = e; return_req = r; entry_type = t; cur_pc = pc; cur_isa = isa; in_delay_slot = s;
    e_dbg = m_dbg; e_depc = m_depc; e_load = 0; e_isa = 0; e_nest = 0; e_drop = 0; e_pc = '0;
    if (e) begin
      e_dbg = f_entry(m_dbg, t, s); e_depc = {pc[31:1], isa};
      e_load = 1; e_pc = VEC; e_isa = 0; e_drop = 1; e_nest = m_dbg[30];
    end else if (r) begin
      e_dbg = f_return(m_dbg); e_load = 1; e_pc = {m_depc[31:1], 1'b0}; e_isa = m_depc[0];
    end
    @(negedge clk);
    entry_req = 0; return_req = 0;
    chk("R2 R3 R4 R7 R10 R11 debug_reg", debug_reg, e_dbg);
    chk("R5 R7 R11 depc_reg", depc_reg, e_depc);
    chk("R6 R7 R11 pc_load", 32'(pc_load), 32'(e_load));
    chk("R8 R11 irq_drop", 32'(irq_drop), 32'(e_drop));
    chk("R9 R11 nested_entry", 32'(nested_entry), 32'(e_nest));
    chk("R11 in_debug", 32'(in_debug), 32'(e_dbg[30]));
    if (e_load) begin
      chk("R6 R7 new_pc", new_pc, e_pc);
      chk("R6 R7 new_isa", 32'(new_isa), 32'(e_isa));
    end
    m_dbg = e_dbg; m_depc = e_depc;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 debug_reg", debug_reg, 32'h0);
    chk("R1 depc_reg", depc_reg, 32'h0);
    chk("R1 flags", {28'h0, in_debug, pc_load, irq_drop, nested_entry}, 32'h0);
    rst_n = 1'b1;
    // R2 one-hot single-step, no slot, isa 1
    step(1, 0, 32'h0000_0001, 32'h8000_1234, 1'b1, 1'b0);
    // R9 nested breakpoint in delay slot, R2 clears old type
    step(1, 0, 32'h0000_0002, 32'h8000_2000, 1'b0, 1'b1);
    step(0, 0, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0);
    // R2 bits outside mask ignored
    step(1, 0, 32'hFFF3_83C0 | 32'h0008_0000, 32'h8000_3001, 1'b1, 1'b0);
    // R7 return restores mode bit from depc
    step(0, 1, 32'h0, 32'h0, 1'b0, 1'b0);
    // R10 entry wins over return
    step(1, 1, 32'h0000_7C00, 32'h9000_0000, 1'b0, 1'b1);
    step(0, 1, 32'h0, 32'h0, 1'b0, 1'b0);
    // return while not in debug mode
    step(0, 1, 32'h0, 32'h0, 1'b0, 1'b0);
    for (int i = 0; i < 400; i++) begin
      int k;
      logic [31:0] t;
      k = $urandom_range(0, 9);
      t = ($urandom_range(0, 1) == 1) ? (32'h1 << $urandom_range(0, 31)) : $urandom;
      step(k < 4, (k >= 4 && k < 7) || k == 9, t, $urandom, 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule